// File: doc/BRIEF.md
# Multi-Level DMA Address Translation Walker

This block turns an inbound DMA address into a system address for one partitionable endpoint (PE). A request carries the DMA address, the PE number and a read/write flag. In the same cycle the block presents a table index, built from the PE number and address bit 59, to an external validation table. That table returns a 64-bit validation entry combinationally. The entry either selects bypass mode or gives the geometry of a tree of translation tables in memory. In bypass mode the address maps straight through in 4 KB pages. Otherwise the block walks up to five levels of tables. Each level is one 8-byte fetch, and the word returned by memory is big-endian.

The block returns either a translated page address, a page mask and two permission bits, or a fault. It handles one walk at a time. The request port and the result port are valid/ready streams. `req_ready` is high only while the block is idle, so a new request waits until the previous result has been taken. The result stays on its outputs, unchanged, until `res_ready` accepts it. The memory request port holds its address until the memory raises `mem_req_ready`. Responses cannot be back-pressured: exactly one response must come back for each accepted fetch.

Validation entry layout (bit 0 is the least significant):
- [63:16] is the table base, in 4 KB units.
- [15:13] is the level count.
- [12:8] is the table-size field.
- [7:5] is reserved.
- [4:0] is the page-size field.

Top module: `dma_xlate_walker`

## Requirements
- R1: `req_ready` is 1 only in the idle state, and a request is taken when `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the cycle after the result is taken. `res_valid` and the result fields stay unchanged while `res_ready` is 0.
- R2: `tve_idx` equals {`req_pe`, `req_addr[59]`}, which is PE×2 plus address bit 59. The entry is sampled from `tve_data` in the accepting cycle.
- R3: The request faults with no memory fetch in either of two cases: address bits [63:60] are not all zero, or `msi32_en` is 1 and address bits [63:16] equal 0xffff.
- R4: A level count field greater than 4 faults with no fetch.
- R5: A page-size field of 0 selects bypass. If entry bit 12 (the top bit of the table-size field) is 1, the result is address AND 0x0003fffffffff000, with mask 0xfff and permission 2'b11, and no fetch is made. If bit 12 is 0, the request faults.
- R6: Outside bypass, a table-size field of 0 faults with no fetch.
- R7: Let the entry shift be the page-size field + 11, the table shift be the table-size field + 8, and the starting shift be table shift × level count + entry shift. Each fetch address is base | (((address >> shift) & ((1 << table shift) − 1)) << 3), where a shift of 64 or more gives an index of 0. The first base is the table base field shifted left by 12.
- R8: A walk that does not fault makes level count + 1 fetches. Each returned word is read big-endian, so byte 0 on the bus is bits [63:56] of the entry. For the next level, the base is the entry with bits [11:0] cleared, and the shift is reduced by the table shift.
- R9: An entry fetched at any level other than the last faults if its bits [1:0] are 00.
- R10: The last entry faults on a write if its bit 1 is 0, and on a read if its bit 0 is 0.
- R11: A successful walk returns the last entry with its low entry-shift bits cleared, a mask of (1 << entry shift) − 1, and a permission equal to the last entry's bits [1:0].
- R12: A memory response with `mem_rsp_err` set ends the walk with a fault, and no further fetch is made.
- R13: While `mem_req_valid` is 1 and `mem_req_ready` is 0, `mem_req_addr` holds steady. Every fetch address is 8-byte aligned.
- R14: A fault result has `res_addr`, `res_mask` and `res_perm` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi32_en | input | 1 | Enables the 32-bit MSI window fault check |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | 64 | Inbound DMA address |
| req_pe | input | PE_W | PE number of the requester |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| tve_idx | output | PE_W+1 | Validation table index |
| tve_data | input | 64 | Validation entry returned for `tve_idx` |
| mem_req_valid | output | 1 | Table fetch request valid |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_addr | output | 64 | Byte address of the 8-byte fetch |
| mem_rsp_valid | input | 1 | Fetch data valid |
| mem_rsp_data | input | 64 | Fetched word, big-endian byte order |
| mem_rsp_err | input | 1 | Fetch failed |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_fault | output | 1 | Translation faulted |
| res_addr | output | 64 | Translated page address |
| res_mask | output | 64 | Page offset mask |
| res_perm | output | 2 | Permission, bit 1 write and bit 0 read |

## Verification
The bench targets the corners where the walk geometry is easiest to get wrong:
- Large table shifts push the first shift past 63. A design that wraps the shift amount would fetch a nonzero index where 0 is due.
- Single-level and four-level walks catch an off-by-one in the level count, which shows up as one fetch too many or too few.
- Entries are returned byte-swapped, so a design that skips the big-endian swap chains to garbage bases.

It also aims at each early exit: an out-of-range address, the MSI window, a bad level count, bypass with and without its enable bit, a zero table size, an indirect entry with 00 permission, a denied read or write, and an error response part-way through a walk. A design that missed any of these would return a translation where a fault with no fetch, or a truncated fetch list, is expected. Withheld `mem_req_ready` and `res_ready` expose outputs that change before their handshake completes.

// File: rtl/dxw_pkg.sv
package dxw_pkg;

  typedef struct packed {
    logic [47:0] tbl_base;
    logic [2:0]  levels;
    logic [4:0]  tsize;
    logic [2:0]  rsvd;
    logic [4:0]  psize;
  } tve_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } walk_state_t;

  localparam logic [63:0] BYPASS_KEEP = 64'h0003_ffff_ffff_f000;
  localparam logic [63:0] PAGE4K_MASK = 64'h0000_0000_0000_0fff;
  localparam int          TSHIFT_BIAS = 8;
  localparam int          ESHIFT_BIAS = 11;

  function automatic logic [63:0] swap64(input logic [63:0] w);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) begin
      r[b*8 +: 8] = w[(7-b)*8 +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/dxw_tve_decode.sv
module dxw_tve_decode #(
  parameter int MAX_LEVELS = 4
) (
  input  logic [63:0] tve,
  input  logic [63:0] addr,
  input  logic        msi32_en,
  output logic        pre_fault,
  output logic        bypass,
  output logic [63:0] base0,
  output logic [63:0] bypass_addr,
  output logic [5:0]  tshift,
  output logic [5:0]  eshift,
  output logic [7:0]  start_shift,
  output logic [2:0]  levels
);
  import dxw_pkg::*;

  tve_t f;
  logic range_bad, msi_hit, lev_bad, geom_bad;
  logic unused_rsvd;

  assign f           = tve_t'(tve);
  assign unused_rsvd = ^f.rsvd;

  always_comb begin
    range_bad   = (addr[63:60] != 4'h0);
    msi_hit     = msi32_en && (addr[63:16] == 48'h0000_0000_ffff);
    lev_bad     = ({29'd0, f.levels} > MAX_LEVELS[31:0]);
    bypass      = (f.psize == 5'd0);
    // bypass needs the enable bit (top of table-size field); walks need a nonzero table size
    geom_bad    = bypass ? !f.tsize[4] : (f.tsize == 5'd0);
    pre_fault   = range_bad | msi_hit | lev_bad | geom_bad;
    tshift      = {1'b0, f.tsize} + 6'(TSHIFT_BIAS);
    eshift      = {1'b0, f.psize} + 6'(ESHIFT_BIAS);
    start_shift = 8'(tshift) * {5'd0, f.levels} + {2'd0, eshift};
    levels      = f.levels;
    base0       = {4'h0, f.tbl_base, 12'h000};
    bypass_addr = addr & BYPASS_KEEP;
  end

endmodule

// File: rtl/dxw_final_check.sv
module dxw_final_check (
  input  logic [63:0] entry,
  input  logic        write,
  input  logic [5:0]  eshift,
  output logic        fault,
  output logic [63:0] out_addr,
  output logic [63:0] out_mask,
  output logic [1:0]  perm
);

  logic [63:0] page_mask;

  always_comb begin
    page_mask = (64'd1 << eshift) - 64'd1;
    fault     = write ? !entry[1] : !entry[0];
    out_addr  = entry & ~page_mask;
    out_mask  = page_mask;
    perm      = entry[1:0];
  end

endmodule

// File: rtl/dxw_walk_ctrl.sv
module dxw_walk_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_addr,
  input  logic        req_write,
  input  logic        dec_fault,
  input  logic        dec_bypass,
  input  logic [63:0] dec_base0,
  input  logic [63:0] dec_bypass_addr,
  input  logic [5:0]  dec_tshift,
  input  logic [5:0]  dec_eshift,
  input  logic [7:0]  dec_start,
  input  logic [2:0]  dec_levels,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  input  logic        mem_rsp_err,
  output logic [63:0] fin_entry,
  output logic        fin_write,
  output logic [5:0]  fin_eshift,
  input  logic        fin_fault,
  input  logic [63:0] fin_addr,
  input  logic [63:0] fin_mask,
  input  logic [1:0]  fin_perm,
  output logic        res_valid,
  input  logic        res_ready,
  output logic        res_fault,
  output logic [63:0] res_addr,
  output logic [63:0] res_mask,
  output logic [1:0]  res_perm
);
  import dxw_pkg::*;

  walk_state_t state;
  logic [63:0] addr_q, base_q;
  logic [7:0]  sh_q;
  logic [5:0]  ts_q, es_q;
  logic [2:0]  lev_q;
  logic        wr_q;
  logic [63:0] shifted, tbl_mask, ent;

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_FETCH);
  assign res_valid     = (state == ST_DONE);

  // fetch address is a pure function of the walk registers, so it holds while waiting
  always_comb begin
    shifted      = (sh_q > 8'd63) ? 64'd0 : (addr_q >> sh_q[5:0]);
    tbl_mask     = (64'd1 << ts_q) - 64'd1;
    mem_req_addr = base_q | ((shifted & tbl_mask) << 3);
  end

  assign ent        = swap64(mem_rsp_data);
  assign fin_entry  = ent;
  assign fin_write  = wr_q;
  assign fin_eshift = es_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      base_q    <= '0;
      sh_q      <= '0;
      ts_q      <= '0;
      es_q      <= '0;
      lev_q     <= '0;
      wr_q      <= 1'b0;
      res_fault <= 1'b0;
      res_addr  <= '0;
      res_mask  <= '0;
      res_perm  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q <= req_addr;
            wr_q   <= req_write;
            base_q <= dec_base0;
            sh_q   <= dec_start;
            ts_q   <= dec_tshift;
            es_q   <= dec_eshift;
            lev_q  <= dec_levels;
            if (dec_fault) begin
              res_fault <= 1'b1;
              res_addr  <= '0;
              res_mask  <= '0;
              res_perm  <= '0;
              state     <= ST_DONE;
            end else if (dec_bypass) begin
              res_fault <= 1'b0;
              res_addr  <= dec_bypass_addr;
              res_mask  <= PAGE4K_MASK;
              res_perm  <= 2'b11;
              state     <= ST_DONE;
            end else begin
              state <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err || ((lev_q != 3'd0) && (ent[1:0] == 2'b00))) begin
              res_fault <= 1'b1;
              res_addr  <= '0;
              res_mask  <= '0;
              res_perm  <= '0;
              state     <= ST_DONE;
            end else if (lev_q != 3'd0) begin
              base_q <= ent & ~PAGE4K_MASK;
              sh_q   <= sh_q - {2'b00, ts_q};
              lev_q  <= lev_q - 3'd1;
              state  <= ST_FETCH;
            end else begin
              res_fault <= fin_fault;
              res_addr  <= fin_fault ? 64'd0 : fin_addr;
              res_mask  <= fin_fault ? 64'd0 : fin_mask;
              res_perm  <= fin_fault ? 2'b00 : fin_perm;
              state     <= ST_DONE;
            end
          end
        end
        default: begin
          if (res_ready) state <= ST_IDLE;
        end
      endcase
    end
  end

  // R13
  memreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R13
  memreq_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid &&
      $stable({res_fault, res_addr, res_mask, res_perm}));

  // R1
  one_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R14
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> (res_addr == 64'd0) && (res_mask == 64'd0) && (res_perm == 2'b00));

  // R11
  mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_fault |-> (((res_mask + 64'd1) & res_mask) == 64'd0) &&
      ((res_addr & res_mask) == 64'd0));

  // R10
  perm_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_fault |-> (wr_q ? res_perm[1] : res_perm[0]));

endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker #(
  parameter int PE_W       = 8,
  parameter int MAX_LEVELS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi32_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_addr,
  input  logic [PE_W-1:0]   req_pe,
  input  logic              req_write,
  output logic [PE_W:0]     tve_idx,
  input  logic [63:0]       tve_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [63:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_fault,
  output logic [63:0]       res_addr,
  output logic [63:0]       res_mask,
  output logic [1:0]        res_perm
);

  logic        dec_fault, dec_bypass;
  logic [63:0] dec_base0, dec_bypass_addr;
  logic [5:0]  dec_tshift, dec_eshift;
  logic [7:0]  dec_start;
  logic [2:0]  dec_levels;
  logic [63:0] fin_entry, fin_addr, fin_mask;
  logic        fin_write, fin_fault;
  logic [5:0]  fin_eshift;
  logic [1:0]  fin_perm;

  // two entries per PE, chosen by address bit 59
  assign tve_idx = {req_pe, req_addr[59]};

  dxw_tve_decode #(.MAX_LEVELS(MAX_LEVELS)) u_decode (
    .tve         (tve_data),
    .addr        (req_addr),
    .msi32_en    (msi32_en),
    .pre_fault   (dec_fault),
    .bypass      (dec_bypass),
    .base0       (dec_base0),
    .bypass_addr (dec_bypass_addr),
    .tshift      (dec_tshift),
    .eshift      (dec_eshift),
    .start_shift (dec_start),
    .levels      (dec_levels)
  );

  dxw_walk_ctrl u_walk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_addr        (req_addr),
    .req_write       (req_write),
    .dec_fault       (dec_fault),
    .dec_bypass      (dec_bypass),
    .dec_base0       (dec_base0),
    .dec_bypass_addr (dec_bypass_addr),
    .dec_tshift      (dec_tshift),
    .dec_eshift      (dec_eshift),
    .dec_start       (dec_start),
    .dec_levels      (dec_levels),
    .mem_req_valid   (mem_req_valid),
    .mem_req_ready   (mem_req_ready),
    .mem_req_addr    (mem_req_addr),
    .mem_rsp_valid   (mem_rsp_valid),
    .mem_rsp_data    (mem_rsp_data),
    .mem_rsp_err     (mem_rsp_err),
    .fin_entry       (fin_entry),
    .fin_write       (fin_write),
    .fin_eshift      (fin_eshift),
    .fin_fault       (fin_fault),
    .fin_addr        (fin_addr),
    .fin_mask        (fin_mask),
    .fin_perm        (fin_perm),
    .res_valid       (res_valid),
    .res_ready       (res_ready),
    .res_fault       (res_fault),
    .res_addr        (res_addr),
    .res_mask        (res_mask),
    .res_perm        (res_perm)
  );

  dxw_final_check u_final (
    .entry    (fin_entry),
    .write    (fin_write),
    .eshift   (fin_eshift),
    .fault    (fin_fault),
    .out_addr (fin_addr),
    .out_mask (fin_mask),
    .perm     (fin_perm)
  );

endmodule

// File: tb/sim_dma_xlate_walker.sv
`timescale 1ns/1ps
module sim_dma_xlate_walker;
  localparam int PE_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msi32_en = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [63:0] req_addr = '0, tve_data = '0, mem_rsp_data = '0;
  logic [PE_W-1:0] req_pe = '0;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0, res_ready = 1'b0;
  logic req_ready, mem_req_valid, res_valid, res_fault;
  logic [PE_W:0] tve_idx;
  logic [63:0] mem_req_addr, res_addr, res_mask;
  logic [1:0] res_perm;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [63:0] plan_ent [0:4];
  logic [63:0] exp_fa [0:4];
  logic        exp_fault;
  logic [63:0] exp_addr, exp_mask;
  logic [1:0]  exp_perm;
  int          exp_nf;

  always #4 clk = ~clk;

  dma_xlate_walker #(.PE_W(PE_W), .MAX_LEVELS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .msi32_en(msi32_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_pe(req_pe), .req_write(req_write), .tve_idx(tve_idx), .tve_data(tve_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .res_valid(res_valid), .res_ready(res_ready), .res_fault(res_fault),
    .res_addr(res_addr), .res_mask(res_mask), .res_perm(res_perm)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [63:0] be_word(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[63-8*i -: 8] = v[8*i +: 8];
    return r;
  endfunction

  function automatic logic [63:0] mk_tve(input logic [47:0] tta, input int lev,
                                         input int ts, input int ps);
    return {tta, 3'(lev), 5'(ts), 3'b000, 5'(ps)};
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  // reference model built from the requirement text
  task automatic model(input logic [63:0] tve, input logic [63:0] a, input bit wr,
                       input bit msi, input int err_at);
    int lev, ts, ps, tb, es, sh;
    logic [63:0] base, idx, e;
    lev = int'(tve[15:13]); ts = int'(tve[12:8]); ps = int'(tve[4:0]);
    exp_fault = 1'b0; exp_addr = '0; exp_mask = '0; exp_perm = '0; exp_nf = 0;
    if (a[63:60] != 4'h0 || (msi && a[63:16] == 48'h0000_0000_ffff)) exp_fault = 1'b1;
    else if (lev > 4) exp_fault = 1'b1;
    else if (ps == 0) begin
      if (!tve[12]) exp_fault = 1'b1;
      else begin
        exp_addr = a & 64'h0003_ffff_ffff_f000; exp_mask = 64'hfff; exp_perm = 2'b11;
      end
    end else if (ts == 0) exp_fault = 1'b1;
    else begin
      tb = ts + 8; es = ps + 11;
      base = {4'h0, tve[63:16], 12'h000};
      sh = tb * lev + es;
      for (int i = 0; i <= lev; i++) begin
        idx = (sh >= 64) ? 64'd0 : (a >> sh);
        idx = idx & ((64'd1 << tb) - 64'd1);
        exp_fa[i] = base | (idx << 3);
        exp_nf = i + 1;
        if (i == err_at) begin exp_fault = 1'b1; break; end
        e = plan_ent[i];
        if (i < lev) begin
          if (e[1:0] == 2'b00) begin exp_fault = 1'b1; break; end
          base = e & ~64'hfff;
          sh = sh - tb;
        end else begin
          if (wr ? !e[1] : !e[0]) exp_fault = 1'b1;
          else begin
            exp_addr = e & ~((64'd1 << es) - 64'd1);
            exp_mask = (64'd1 << es) - 64'd1;
            exp_perm = e[1:0];
          end
        end
      end
    end
    if (exp_fault) begin exp_addr = '0; exp_mask = '0; exp_perm = '0; end
  endtask

  task automatic run_walk(input logic [63:0] tve, input logic [63:0] a,
                          input logic [PE_W-1:0] pe, input bit wr, input bit msi,
                          input int err_at, input string tag);
    int nf, dly;
    bit accp, rspp, held, seen, fin;
    logic r_f;
    logic [63:0] r_a, r_m;
    logic [1:0] r_p;
    nf = 0; dly = 0; accp = 0; rspp = 0; held = 0; seen = 0; fin = 0;
    r_f = 0; r_a = 0; r_m = 0; r_p = 0;
    model(tve, a, wr, msi, err_at);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_pe = pe; req_write = wr; msi32_en = msi; tve_data = tve;
    #1;
    chk(tve_idx == {pe, a[59]}, "R2", "table index", 64'(tve_idx), 64'({pe, a[59]}));
    chk(req_ready == 1'b1, "R1", "ready when idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0; tve_data = rnd64();
    chk(req_ready == 1'b0, "R1", "busy after accept", 64'(req_ready), 64'd0);
    for (int cyc = 0; cyc < 300 && !fin; cyc++) begin
      if (cyc > 0) @(negedge clk);
      mem_req_ready = 1'b0;
      if (rspp) begin
        mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; rspp = 0; nf++;
      end else if (accp) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = be_word(plan_ent[nf < 5 ? nf : 0]);
          mem_rsp_err = (nf == err_at);
          rspp = 1; accp = 0;
        end else dly--;
      end
      if (!accp && !rspp && mem_req_valid) begin
        if (nf < exp_nf)
          chk(mem_req_addr == exp_fa[nf], held ? "R13" : "R7", "fetch address",
              mem_req_addr, exp_fa[nf]);
        else
          chk(1'b0, "R8", "unexpected fetch", 64'(nf), 64'(exp_nf));
        if ($urandom % 3 != 0) begin
          mem_req_ready = 1'b1; accp = 1; dly = int'($urandom % 3); held = 0;
        end else held = 1;
      end
      if (res_valid) begin
        if (!seen) begin
          seen = 1; r_f = res_fault; r_a = res_addr; r_m = res_mask; r_p = res_perm;
        end else begin
          chk({r_f, r_a, r_m, r_p} == {res_fault, res_addr, res_mask, res_perm}, "R1",
              "result held under back-pressure", res_addr, r_a);
          chk(res_fault == exp_fault, tag, "fault", 64'(res_fault), 64'(exp_fault));
          chk(res_addr == exp_addr, exp_fault ? "R14" : tag, "address", res_addr, exp_addr);
          chk(res_mask == exp_mask, exp_fault ? "R14" : tag, "mask", res_mask, exp_mask);
          chk(res_perm == exp_perm, exp_fault ? "R14" : tag, "perm", 64'(res_perm), 64'(exp_perm));
          res_ready = 1'b1; fin = 1;
        end
      end
    end
    if (!fin) chk(1'b0, tag, "result timeout", 64'd0, 64'd1);
    @(negedge clk);
    res_ready = 1'b0; mem_rsp_valid = 1'b0;
    chk(req_ready == 1'b1, "R1", "idle after result taken", 64'(req_ready), 64'd1);
    chk(nf == exp_nf, "R8", "fetch count", 64'(nf), 64'(exp_nf));
  endtask

  initial begin
    logic [63:0] a, e, tve;
    int lev, ts, ps, err_at;
    bit wr, msi;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 5; i++) plan_ent[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
    chk(res_valid == 1'b0, "R1", "reset result idle", 64'(res_valid), 64'd0);
    chk(mem_req_valid == 1'b0, "R13", "reset no fetch", 64'(mem_req_valid), 64'd0);

    // directed corners
    run_walk(mk_tve(48'h1234, 0, 16, 0), 64'h0123_4567_89ab_cdef, 8'h05, 1, 0, -1, "R5");
    run_walk(mk_tve(48'h1234, 0, 15, 0), 64'h0123_4567_89ab_cdef, 8'h05, 0, 0, -1, "R5");
    run_walk(mk_tve(48'h1234, 5, 4, 3), 64'h0000_0000_0001_0000, 8'h02, 0, 0, -1, "R4");
    run_walk(mk_tve(48'h1234, 1, 0, 3), 64'h0000_0000_0001_0000, 8'h02, 0, 0, -1, "R6");
    run_walk(mk_tve(48'h1234, 1, 4, 3), 64'h1000_0000_0000_0000, 8'h02, 0, 0, -1, "R3");
    run_walk(mk_tve(48'h1234, 0, 4, 1), 64'h0000_0000_ffff_0040, 8'h03, 0, 1, -1, "R3");
    plan_ent[0] = 64'h0000_0012_3456_7001;
    run_walk(mk_tve(48'h1234, 0, 4, 1), 64'h0000_0000_ffff_0040, 8'h03, 0, 0, -1, "R11");
    plan_ent[0] = 64'h0000_0000_0055_5000; plan_ent[1] = 64'h0000_00ab_cdef_0003;
    run_walk(mk_tve(48'h0042, 1, 9, 1), 64'h0800_0012_3456_7890, 8'h7f, 0, 0, -1, "R9");
    plan_ent[0] = 64'h0000_0000_0077_7001;
    run_walk(mk_tve(48'h0042, 0, 9, 1), 64'h0000_0012_3456_7890, 8'h11, 1, 0, -1, "R10");
    plan_ent[0] = 64'h0000_0000_0077_7002;
    run_walk(mk_tve(48'h0042, 0, 9, 1), 64'h0000_0012_3456_7890, 8'h11, 0, 0, -1, "R10");
    plan_ent[0] = 64'h0000_0000_0010_0003; plan_ent[1] = 64'h0000_0000_0020_0001;
    plan_ent[2] = 64'h0000_0000_0030_0003;
    run_walk(mk_tve(48'h0099, 2, 3, 1), 64'h0000_0123_4567_89a8, 8'h21, 0, 0, 1, "R12");
    plan_ent[0] = 64'h0000_0000_0011_0001; plan_ent[1] = 64'h0000_0000_0022_0002;
    plan_ent[2] = 64'h0000_0000_0033_0003; plan_ent[3] = 64'h0000_0000_0044_0001;
    plan_ent[4] = 64'h0000_0abc_def1_2003;
    run_walk(mk_tve(48'h0abc, 4, 1, 1), 64'h0000_0fed_cba9_8760, 8'h40, 1, 0, -1, "R7");
    run_walk(mk_tve(48'h0abc, 4, 31, 20), 64'h0fed_cba9_8765_4320, 8'h41, 0, 0, -1, "R8");

    // constrained random walks
    for (int n = 0; n < 300; n++) begin
      lev = ($urandom % 16 == 0) ? 5 + int'($urandom % 3) : int'($urandom % 5);
      ts  = ($urandom % 8 == 0) ? int'($urandom % 32) : 1 + int'($urandom % 12);
      ps  = ($urandom % 10 == 0) ? 0 : 1 + int'($urandom % 31);
      tve = mk_tve(rnd64()[47:0], lev, ts, ps);
      for (int i = 0; i < 5; i++) begin
        e = rnd64();
        if ($urandom % 12 != 0 && e[1:0] == 2'b00) e[0] = 1'b1;
        plan_ent[i] = e;
      end
      err_at = ($urandom % 16 == 0) ? int'($urandom % 5) : -1;
      wr  = $urandom % 2 == 1;
      msi = $urandom % 2 == 1;
      a = {($urandom % 20 == 0) ? 4'($urandom) : 4'h0, rnd64()[59:0]};
      if (msi && $urandom % 8 == 0) a = {48'h0000_0000_ffff, 16'($urandom)};
      run_walk(tve, a, PE_W'($urandom), wr, msi, err_at, "R11");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule